// File: doc/BRIEF.md
# Prefix-Extended OR Execution Unit

This block executes one instruction from a 16-bit instruction stream: a logical OR of two registers. Immediate-extension prefix words may come before it. The unit holds a 16-entry, 32-bit register file, a small latch for the pending prefix payloads, and five condition flags: negative, zero, overflow, carry and interrupt-enable.

With no pending prefix, the OR merges the source register into the destination register. With one or two pending prefixes, the OR takes the source register and an immediate built from the prefix payloads. It writes the result to the destination and leaves the source register untouched. An OR that sits in a branch delay slot, marked by `in_dslot`, always uses the plain register form.

Instruction words arrive on a valid/ready stream. `in_ready` is high whenever reset is released, and the unit never applies back-pressure. A word is consumed on every clock edge where `in_valid` and `in_ready` are both high, and its effect is complete at that edge. When `in_valid` is low, `in_word` and `in_dslot` are ignored. A combinational read port exposes any register.

Top module: `prefix_or_unit`

## Requirements
- R1: A word whose bits 15:8 are 0x36 is an OR, with the source index in bits 7:4 and the destination index in bits 3:0. With no pending prefix, the destination becomes destination OR source at the edge that accepts the word. Any of r0 to r15 may be used.
- R2: After exactly one pending prefix with payload p, an OR writes source OR zero-extended 13-bit p to the destination, and the source register is left unchanged.
- R3: After two pending prefixes, the older payload forms bits 25:13 and the newer payload forms bits 12:0 of a zero-extended 26-bit immediate. This immediate is ORed with the source. For example, payloads 0x1 then 0x1fff with OR r1,r2 give r1 = r2 | 0x00003fff.
- R4: When more than two prefixes arrive in a row, only the two most recent are kept, with the older of them in the upper field.
- R5: A prefix word has bits 15:13 equal to 3'b110 and carries its payload in bits 12:0. Any accepted word that is neither a prefix nor an OR changes no register and discards the pending prefixes.
- R6: An OR sets the negative flag from result bit 31 and sets the zero flag when all 32 result bits are 0. It clears the overflow flag and leaves carry and interrupt-enable unchanged. Reset values are negative 0, zero 0, overflow 1, carry 1 and interrupt-enable 0.
- R7: An OR accepted with `in_dslot` high uses the plain register form regardless of pending prefixes, and it discards them.
- R8: Every accepted OR clears the pending prefix count, so the next OR without its own prefix uses the plain register form.
- R9: `in_ready` is high whenever reset is released. A cycle with `in_valid` low changes no register or flag and keeps the pending prefixes.
- R10: Reset loads register i with its 4-bit index repeated eight times, for example r8 = 0x88888888 and r0 = 0.
- R11: `rd_data` combinationally shows the register selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can accept a word |
| in_word | input | 16 | Instruction word |
| in_dslot | input | 1 | Word sits in a branch delay slot |
| rd_addr | input | 4 | Read port register index |
| rd_data | output | 32 | Read port register contents |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_ie | output | 1 | Interrupt-enable flag |

## Verification
The OR is run with no prefix, one prefix, two prefixes and a run of three prefixes. Comparing the results separates the plain destination-merge form, the 13-bit immediate, the concatenated 26-bit immediate, and the shift that keeps only the two newest payloads. Operands are chosen so that the result has bit 31 set in one case and is all zero in another, which tests the negative and zero flags.

Prefixes are also followed by an unrelated word, by an OR in a delay slot, and by an idle cycle that carries an OR pattern with valid low. These show whether pending prefixes are discarded, ignored or kept, and a further plain OR confirms that the count was cleared.

// File: rtl/pfx_or_pkg.sv
package pfx_or_pkg;

  typedef enum logic [1:0] {
    OPK_IDLE   = 2'd0,
    OPK_PREFIX = 2'd1,
    OPK_OR     = 2'd2,
    OPK_OTHER  = 2'd3
  } op_kind_t;

  // Reset contents of register idx: its low nibble repeated across the word.
  function automatic logic [31:0] reg_seed(input int idx);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) v[k*4 +: 4] = 4'(idx);
    return v;
  endfunction

endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_or_pkg::*;
#(
  parameter int          IW      = 16,
  parameter int          PW      = 13,
  parameter int          AW      = 4,
  parameter logic [7:0]  OR_OPC  = 8'h36,
  parameter logic [2:0]  PFX_OPC = 3'b110
) (
  input  logic          valid,
  input  logic [IW-1:0] word,
  output op_kind_t      kind,
  output logic [AW-1:0] src_idx,
  output logic [AW-1:0] dst_idx,
  output logic [PW-1:0] payload
);

  localparam int OPC_LO = IW - 8;
  localparam int PFX_LO = IW - 3;

  always_comb begin
    src_idx = word[2*AW-1:AW];
    dst_idx = word[AW-1:0];
    payload = word[PW-1:0];
    if (!valid)                          kind = OPK_IDLE;
    else if (word[IW-1:PFX_LO] == PFX_OPC) kind = OPK_PREFIX;
    else if (word[IW-1:OPC_LO] == OR_OPC)  kind = OPK_OR;
    else                                 kind = OPK_OTHER;
  end

endmodule

// File: rtl/pfx_latch.sv
module pfx_latch #(
  parameter int PW = 13,
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  logic [PW-1:0] payload,
  output logic [1:0]    cnt,
  output logic [XW-1:0] imm
);

  localparam int WIDE = 2 * PW;

  logic [PW-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= 2'd0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (load) begin
      hi_q <= lo_q;
      lo_q <= payload;
      cnt  <= (cnt == 2'd2) ? 2'd2 : cnt + 2'd1;
    end else if (clr) begin
      cnt <= 2'd0;
    end
  end

  always_comb begin
    imm = '0;
    if (cnt == 2'd1) imm[PW-1:0]   = lo_q;
    else             imm[WIDE-1:0] = {hi_q, lo_q};
  end

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (cnt == 2'd0));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);

  // R3
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hi_q == $past(lo_q)) && (lo_q == $past(payload)));

endmodule

// File: rtl/or_regfile.sv
module or_regfile
  import pfx_or_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [DW-1:0] rc_data
);

  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= DW'(reg_seed(g));
      else if (we && waddr == AW'(g))    mem[g] <= wdata;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/prefix_or_unit.sv
module prefix_or_unit
  import pfx_or_pkg::*;
#(
  parameter int   NREG    = 16,
  parameter int   DW      = 32,
  parameter int   IW      = 16,
  parameter int   PW      = 13,
  parameter logic V_INIT  = 1'b1,
  parameter logic C_INIT  = 1'b1,
  parameter logic IE_INIT = 1'b0,
  localparam int  AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_word,
  input  logic          in_dslot,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          flag_ie
);

  op_kind_t      kind;
  logic [AW-1:0] src_idx, dst_idx;
  logic [PW-1:0] payload;
  logic [1:0]    pcnt;
  logic [DW-1:0] imm, src_val, dst_val, opa, opb, result;
  logic          acc, do_or, use_imm;

  assign in_ready = rst_n;
  assign acc      = in_valid && in_ready;

  pfx_decode #(.IW(IW), .PW(PW), .AW(AW)) u_dec (
    .valid   (acc),
    .word    (in_word),
    .kind    (kind),
    .src_idx (src_idx),
    .dst_idx (dst_idx),
    .payload (payload)
  );

  pfx_latch #(.PW(PW), .XW(DW)) u_pfx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (kind == OPK_PREFIX),
    .clr     (kind == OPK_OR || kind == OPK_OTHER),
    .payload (payload),
    .cnt     (pcnt),
    .imm     (imm)
  );

  assign do_or   = (kind == OPK_OR);
  assign use_imm = (pcnt != 2'd0) && !in_dslot;
  assign opa     = use_imm ? src_val : dst_val;
  assign opb     = use_imm ? imm     : src_val;
  assign result  = opa | opb;

  or_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (do_or),
    .waddr   (dst_idx),
    .wdata   (result),
    .ra_addr (src_idx),
    .ra_data (src_val),
    .rb_addr (dst_idx),
    .rb_data (dst_val),
    .rc_addr (rd_addr),
    .rc_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= V_INIT;
      flag_c  <= C_INIT;
      flag_ie <= IE_INIT;
    end else begin
      flag_c  <= flag_c;
      flag_ie <= flag_ie;
      if (do_or) begin
        flag_n <= result[DW-1];
        flag_z <= (result == '0);
        flag_v <= 1'b0;
      end
    end
  end

  // R6
  v_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_or |=> !flag_v);

  // R6
  carry_ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ($stable(flag_c) && $stable(flag_ie)));

  // R9
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_v)));

  // R7
  dslot_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_or && in_dslot) |=> (rd_addr != $past(dst_idx)) ||
      (rd_data == ($past(dst_val) | $past(src_val))));

endmodule

// File: tb/tb_prefix_or_unit.sv
module tb_prefix_or_unit;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        in_dslot = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        flag_n, flag_z, flag_v, flag_c, flag_ie;

  always #2 clk = ~clk;

  prefix_or_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_dslot(in_dslot), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .flag_ie(flag_ie)
  );

  typedef struct {
    logic [3:0]  a;
    logic [31:0] v;
    logic        n, z, ov, c, ie;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;

  logic [31:0] mregs [16];
  logic [1:0]  mcnt;
  logic [12:0] mhi, mlo;
  logic        mn, mz, mv;

  function automatic exp_t mk(input logic [3:0] a, input string tag);
    exp_t e;
    e.a = a; e.v = mregs[a]; e.n = mn; e.z = mz; e.ov = mv;
    e.c = 1'b1; e.ie = 1'b0; e.tag = tag;
    return e;
  endfunction

  task automatic expect_reg(input logic [3:0] a, input string tag);
    q.push_back(mk(a, tag));
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items at the falling edge and compares them.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        rd_addr = e.a;
        #0.1;
        tests++;
        if (rd_data !== e.v || flag_n !== e.n || flag_z !== e.z ||
            flag_v !== e.ov || flag_c !== e.c || flag_ie !== e.ie) begin
          fails++;
          $display("FAIL %s r%0d actual=%h nzvci=%b%b%b%b%b expected=%h nzvci=%b%b%b%b%b",
                   e.tag, e.a, rd_data, flag_n, flag_z, flag_v, flag_c, flag_ie,
                   e.v, e.n, e.z, e.ov, e.c, e.ie);
        end
      end
    end
  end

  task automatic send(input logic [15:0] w, input logic ds);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_dslot = ds;
    @(posedge clk);
    #0.5;
    in_valid = 1'b0; in_dslot = 1'b0;
  endtask

  task automatic prefix(input logic [12:0] p);
    send({3'b110, p}, 1'b0);
    mhi = mlo; mlo = p;
    mcnt = (mcnt == 2'd2) ? 2'd2 : mcnt + 2'd1;
  endtask

  task automatic other(input logic [15:0] w);
    send(w, 1'b0);
    mcnt = 2'd0;
  endtask

  task automatic do_or(input logic [3:0] s, input logic [3:0] d, input logic ds,
                       input string tag);
    logic [31:0] res;
    if (mcnt != 2'd0 && !ds)
      res = mregs[s] | ((mcnt == 2'd1) ? {19'b0, mlo} : {6'b0, mhi, mlo});
    else
      res = mregs[d] | mregs[s];
    send({8'h36, s, d}, ds);
    mregs[d] = res; mn = res[31]; mz = (res == 32'h0); mv = 1'b0; mcnt = 2'd0;
    expect_reg(d, tag);
    if (s != d) expect_reg(s, tag);
  endtask

  task automatic idle_cycle(input logic [15:0] junk);
    @(negedge clk);
    in_valid = 1'b0; in_word = junk; in_dslot = 1'b0;
    @(posedge clk);
    #0.5;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mregs[i] = {8{4'(i)}};
    mcnt = 2'd0; mhi = '0; mlo = '0; mn = 1'b0; mz = 1'b0; mv = 1'b1;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // R10 R6: reset contents and flags
    for (int i = 0; i < 16; i++) expect_reg(4'(i), "R10");
    @(negedge clk); @(negedge clk);
    #0.3;
    // R9: ready after reset
    check("R9 ready", 64'(in_ready), 64'd1);

    do_or(4'd2, 4'd1, 1'b0, "R1 plain");         // 0x33333333
    do_or(4'd0, 4'd0, 1'b0, "R6 zero");          // Z set
    do_or(4'd3, 4'd8, 1'b0, "R6 negative");      // N set
    prefix(13'h0001); prefix(13'h1fff);
    do_or(4'd2, 4'd1, 1'b0, "R3 two prefixes");  // r2 | 0x3fff
    prefix(13'h10a5);
    do_or(4'd5, 4'd4, 1'b0, "R2 one prefix");
    prefix(13'h0001); prefix(13'h0002); prefix(13'h0003);
    do_or(4'd7, 4'd6, 1'b0, "R4 three prefixes");
    prefix(13'h0fff);
    other(16'h0000);
    do_or(4'd10, 4'd9, 1'b0, "R5 other clears");
    prefix(13'h0777);
    other(16'h3712);
    expect_reg(4'd2, "R5 no write");
    do_or(4'd12, 4'd11, 1'b0, "R5 plain after other");
    prefix(13'h1234); prefix(13'h0abc);
    do_or(4'd14, 4'd13, 1'b1, "R7 delay slot");
    do_or(4'd15, 4'd13, 1'b0, "R7 plain after slot");
    prefix(13'h0100);
    do_or(4'd0, 4'd0, 1'b0, "R8 imm into r0");
    do_or(4'd3, 4'd0, 1'b0, "R8 plain next");
    prefix(13'h0040);
    idle_cycle(16'h3621);
    expect_reg(4'd1, "R9 idle no write");
    do_or(4'd9, 4'd2, 1'b0, "R9 prefix kept");
    for (int i = 0; i < 16; i++) expect_reg(4'(i), "R11 readback");
    @(negedge clk); @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule